// File: doc/BRIEF.md
# Phase-Gated Fine-Step Pulse-Width Modulator

This block produces one pulse-width-modulated output whose period equals one cycle of a base clock. It resolves the on-time in steps of one eighth of that period, and it needs no counter running eight times faster than the base clock. It receives four quarter-period-shifted copies of the base clock, all at 50% duty. It also receives a double-rate clock and a quadruple-rate clock, each with its complement. Gating each phase copy with the double-rate clock or its complement gives four quarter-period slices. Gating each slice again with the quadruple-rate clock or its complement gives eight eighth-period windows. The windows do not overlap and follow one another in phase order.

A 3-bit duty code is captured on the rising edge of the zero-phase clock. The output is then the OR of windows 0 up to the code. It therefore goes high at the start of the period and drops at the start of window code+1. Code 7 keeps the output high for the whole period. An asynchronous active-low reset is released in step with the zero-phase clock. While reset is active, the output is held low and the captured code is cleared to zero.

Top module: `phase_window_pwm`

## Requirements
- R1: After reset release, the output is high in the first eighth of every base period (slot 0, which starts at the rising edge of the zero-phase clock), for every duty code.
- R2: For a captured code d, the output is high in exactly d+1 of the eight eighth-period slots of the period.
- R3: Code 7 keeps the output high in all eight slots, including the last slot before the next rising edge of the zero-phase clock.
- R4: Code 0 gives the shortest pulse, which lasts one slot (one eighth of the period).
- R5: A duty code is captured only at the rising edge of the zero-phase clock. A change of the duty input partway through a period leaves the rest of that period unchanged, and the new code governs the following period.
- R6: While the reset input is low, and until the synchronized release, the output stays low in every slot. The captured code is cleared to 0.
- R7: The eight windows are mutually exclusive. Window k covers slot k, counted from the rising edge of the zero-phase clock. The high slots of the output are therefore contiguous and begin at slot 0 (bit pattern 2^(d+1)-1 with slot 0 as bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| ph_000_i | input | 1 | Base clock, 0° copy, 50% duty |
| ph_090_i | input | 1 | Base clock shifted by a quarter period |
| ph_180_i | input | 1 | Base clock shifted by half a period |
| ph_270_i | input | 1 | Base clock shifted by three quarters of a period |
| clk_x2_i | input | 1 | Double-rate clock, rising with the base clock |
| clk_x2_n_i | input | 1 | Complement of the double-rate clock |
| clk_x4_i | input | 1 | Quadruple-rate clock, rising with the base clock |
| clk_x4_n_i | input | 1 | Complement of the quadruple-rate clock |
| duty_i | input | 3 | Duty code d; the on-time is (d+1)/8 of a period |
| pwm_o | output | 1 | Modulated output |

## Verification
The embedded assertions are sampled on every zero-phase rising edge. They check that at most one window is active, that the last window is the one active just before the wrap, and that the output in that last slot agrees with the code that governed the period. They also check that the output is low while the synchronized reset is held. Only the bench scenarios can show the on-time slot by slot within a period. They also show that a mid-period code change leaves the current pulse intact and takes effect one period later, and that an asynchronous reset silences the output at once. The bench samples the output at the centre of every eighth slot and compares the pattern against a thermometer computed from the code.

// File: rtl/pwm_win_pkg.sv
package pwm_win_pkg;
  // Number of phase copies of the base clock (quarter-period spacing).
  localparam int unsigned N_PHASE = 4;
  // Each phase slice is split in two by the quadruple-rate clock.
  localparam int unsigned N_WIN   = 2 * N_PHASE;
  // Width of the duty code that selects the falling window.
  localparam int unsigned DUTY_W  = $clog2(N_WIN);
  // Synchronizer depth for the reset release.
  localparam int unsigned RST_SYNC_STAGES = 2;

  typedef logic [N_WIN-1:0]   win_vec_t;
  typedef logic [DUTY_W-1:0]  duty_t;
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pwm_window_bank.sv
module pwm_window_bank
  import pwm_win_pkg::*;
(
  input  logic              rst_n,
  input  logic [N_PHASE-1:0] phase_i,
  input  logic              x2_i,
  input  logic              x2_n_i,
  input  logic              x4_i,
  input  logic              x4_n_i,
  output win_vec_t          win_o
);
  logic [N_PHASE-1:0] slice;

  // Even phases overlap the high half of the double-rate clock in their
  // leading quarter, odd phases overlap its low half.
  for (genvar p = 0; p < N_PHASE; p++) begin : g_slice
    if ((p % 2) == 0) begin : g_even
      assign slice[p] = phase_i[p] & x2_i;
    end else begin : g_odd
      assign slice[p] = phase_i[p] & x2_n_i;
    end
  end

  // Each quarter slice is halved: leading eighth with the high half of the
  // quadruple-rate clock, trailing eighth with its low half.
  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    if ((w % 2) == 0) begin : g_lead
      assign win_o[w] = slice[w/2] & x4_i;
    end else begin : g_trail
      assign win_o[w] = slice[w/2] & x4_n_i;
    end
  end

  AST_WIN_ONEHOT: assert property (@(posedge phase_i[0]) disable iff (!rst_n)
    $onehot0(win_o)); // R7
  AST_LAST_WIN_AT_WRAP: assert property (@(posedge phase_i[0]) disable iff (!rst_n)
    win_o == win_vec_t'(1) << (N_WIN-1)); // R7
endmodule

// File: rtl/pwm_duty_capture.sv
module pwm_duty_capture
  import pwm_win_pkg::*;
(
  input  logic  clk,
  input  logic  rst_sync_n,
  input  duty_t duty_i,
  output duty_t duty_q
);
  duty_t duty_d;
  logic  load_en;

  always_comb begin
    load_en = rst_sync_n;
    duty_d  = load_en ? duty_i : duty_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      duty_q <= '0;
    end else begin
      duty_q <= duty_d;
    end
  end
endmodule

// File: rtl/pwm_edge_mask.sv
module pwm_edge_mask
  import pwm_win_pkg::*;
(
  input  logic     run_i,
  input  duty_t    duty_i,
  input  win_vec_t win_i,
  output logic     pwm_o
);
  win_vec_t keep;

  // Thermometer mask: windows 0..duty stay, the rest are dropped.
  for (genvar w = 0; w < N_WIN; w++) begin : g_mask
    assign keep[w] = (DUTY_W'(w) <= duty_i);
  end

  assign pwm_o = run_i & (|(win_i & keep));
endmodule

// File: rtl/phase_window_pwm.sv
module phase_window_pwm
  import pwm_win_pkg::*;
(
  input  logic        rst_n,
  input  logic        ph_000_i,
  input  logic        ph_090_i,
  input  logic        ph_180_i,
  input  logic        ph_270_i,
  input  logic        clk_x2_i,
  input  logic        clk_x2_n_i,
  input  logic        clk_x4_i,
  input  logic        clk_x4_n_i,
  input  logic [2:0]  duty_i,
  output logic        pwm_o
);
  logic      rst_sync_n;
  duty_t     duty_q;
  win_vec_t  win;
  logic [N_PHASE-1:0] phases;

  assign phases = {ph_270_i, ph_180_i, ph_090_i, ph_000_i};

  pwm_rst_sync #(
    .STAGES (RST_SYNC_STAGES)
  ) i_rst_sync (
    .clk        (ph_000_i),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwm_window_bank i_window_bank (
    .rst_n   (rst_sync_n),
    .phase_i (phases),
    .x2_i    (clk_x2_i),
    .x2_n_i  (clk_x2_n_i),
    .x4_i    (clk_x4_i),
    .x4_n_i  (clk_x4_n_i),
    .win_o   (win)
  );

  pwm_duty_capture i_duty_capture (
    .clk        (ph_000_i),
    .rst_sync_n (rst_sync_n),
    .duty_i     (duty_t'(duty_i)),
    .duty_q     (duty_q)
  );

  pwm_edge_mask i_edge_mask (
    .run_i  (rst_sync_n),
    .duty_i (duty_q),
    .win_i  (win),
    .pwm_o  (pwm_o)
  );

  // The last slot before the wrap is high only for the full-scale code.
  AST_PWM_AT_WRAP: assert property (@(posedge ph_000_i) disable iff (!rst_sync_n)
    pwm_o == (duty_q == '1)); // R3
  AST_RESET_LOW: assert property (@(posedge ph_000_i) disable iff (!rst_n)
    !rst_sync_n |-> !pwm_o); // R6
endmodule

// File: tb/test_phase_window_pwm.sv
`timescale 1ns/1ps
module test_phase_window_pwm;
  logic       rst_n;
  logic [2:0] slot;
  logic [2:0] duty;
  logic       pwm;
  int         checks;
  int         errors;

  // Eight slots of 1.25 ns make a 10 ns (100 MHz) base period.
  initial begin
    slot = 3'd0;
    forever begin
      #1.25;
      slot = slot + 3'd1;
    end
  end

  wire ph0   = ~slot[2];
  wire ph90  = slot[2] ^ slot[1];
  wire ph180 = slot[2];
  wire ph270 = ~(slot[2] ^ slot[1]);
  wire x2    = ~slot[1];
  wire x4    = ~slot[0];

  phase_window_pwm i_phase_window_pwm (
    .rst_n      (rst_n),
    .ph_000_i   (ph0),
    .ph_090_i   (ph90),
    .ph_180_i   (ph180),
    .ph_270_i   (ph270),
    .clk_x2_i   (x2),
    .clk_x2_n_i (~x2),
    .clk_x4_i   (x4),
    .clk_x4_n_i (~x4),
    .duty_i     (duty),
    .pwm_o      (pwm)
  );

  // Samples one period at the centre of each slot; optionally changes the
  // duty input between slot 2 and slot 3.
  task automatic measure(input logic chg, input logic [2:0] nd,
                         output logic [7:0] pat);
    @(posedge ph0);
    for (int k = 0; k < 8; k++) begin
      if (chg && k == 3) duty = nd;
      #0.625;
      pat[k] = pwm;
      if (k < 7) #0.625;
    end
  endtask

  task automatic check(input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [7:0] therm(input int d);
    return 8'((9'd1 << (d + 1)) - 9'd1);
  endfunction

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] pat;
    checks = 0;
    errors = 0;
    rst_n  = 1'b0;
    duty   = 3'd5;
    measure(1'b0, 3'd0, pat);
    check("R6 reset holds output low", pat, 8'h00);
    measure(1'b0, 3'd0, pat);
    check("R6 reset holds output low", pat, 8'h00);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) measure(1'b0, 3'd0, pat);

    // Sweep every code twice, in ascending and descending order.
    for (int pass = 0; pass < 2; pass++) begin
      for (int j = 0; j < 8; j++) begin
        int d;
        d = (pass == 0) ? j : 7 - j;
        duty = 3'(d);
        measure(1'b0, 3'd0, pat);   // code captured at this period's start
        check("R1 slot 0 high", {7'd0, pat[0]}, 8'd1);
        check("R2 R7 on-time pattern", pat, therm(d));
        checks++;
        if ($countones(pat) != d + 1) begin
          errors++;
          $display("FAIL R2: actual %0d slots expected %0d", $countones(pat), d + 1);
        end
        if (d == 7) check("R3 full period high", pat, 8'hFF);
        if (d == 0) check("R4 minimum one slot", pat, 8'h01);
      end
    end

    // Mid-period changes must not disturb the running period.
    duty = 3'd1;
    measure(1'b0, 3'd0, pat);
    measure(1'b1, 3'd6, pat);
    check("R5 current period kept", pat, therm(1));
    measure(1'b0, 3'd0, pat);
    check("R5 new code next period", pat, therm(6));
    measure(1'b1, 3'd0, pat);
    check("R5 current period kept", pat, therm(6));
    measure(1'b0, 3'd0, pat);
    check("R5 new code next period", pat, therm(0));

    // Reset asserted in the middle of a high stretch.
    duty = 3'd7;
    measure(1'b0, 3'd0, pat);
    measure(1'b0, 3'd0, pat);
    check("R3 full period high", pat, 8'hFF);
    @(posedge ph0);
    #3.0;
    rst_n = 1'b0;
    #0.1;
    checks++;
    if (pwm !== 1'b0) begin
      errors++;
      $display("FAIL R6: actual %b expected 0 right after reset", pwm);
    end
    measure(1'b0, 3'd0, pat);
    check("R6 reset holds output low", pat, 8'h00);
    #2.0;
    rst_n = 1'b1;
    measure(1'b0, 3'd0, pat);
    check("R6 low until synchronized release", pat, 8'h00);
    measure(1'b0, 3'd0, pat);
    duty = 3'd3;
    measure(1'b0, 3'd0, pat);
    check("R2 after reset release", pat, therm(3));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule